// File: doc/BRIEF.md
# Serial Gamepad Button Reader

This block drives an eight-button serial gamepad and keeps a snapshot of its buttons ready for a host. Sixty times per second it raises the pad's latch line. It then clocks the pad's internal shift register with seven pulses and samples one data bit at the end of each low window. When the eighth bit has been captured, the whole byte is written at once into a holding register. Until that moment the previous complete byte is kept, so the host never sees a mix of two scans.

The host fetches the snapshot with a request/response handshake. A request is taken when `req_valid` and `req_ready` are both high. On the next clock, `rsp_valid` rises with the byte that the holding register held at the moment the request was taken. The response is a stream beat under back-pressure: `rsp_valid` and `rsp_buttons` stay constant until `rsp_ready` is high at a clock edge. While a response is pending, `req_ready` is low, so only one request is outstanding at a time. Several instances can serve several pads. All timing comes from the system clock frequency parameter.

Top module: `pad_reader`

## Requirements
- R1: A scan starts once every CLK_HZ/POLL_HZ clock cycles (1/60 s by default). With a synchronous reset released before clock edge 1, the latch output first goes high after edge CLK_HZ/POLL_HZ and again after every further period.
- R2: The latch output stays high for exactly LATCH_US microseconds (12 us) of clock cycles, then goes low.
- R3: After the latch falls, the pulse output stays low for HALF_US (6 us) of cycles. It then makes seven pulses, each HALF_US high and HALF_US low. Latch and pulse are never high together.
- R4: The pad data input is active low and passes through a two-flop synchronizer. One bit is sampled at the last cycle of each of the eight low windows. The stored byte uses 1 for pressed: the first bit (A) goes to bit 7, then B, Select, Start, Up, Down and Left, down to the eighth bit (Right) at bit 0.
- R5: The holding register is written only on the clock edge of the eighth sample. A request served at any point during a scan returns the byte from the previous complete scan.
- R6: All eight buttons are stored independently, so any combination of pressed buttons is reported exactly, including none and all.
- R7: A request taken on an edge with req_valid and req_ready high gives rsp_valid high after that edge, with rsp_buttons equal to the holding register before that edge. The response stays unchanged until an edge with rsp_ready high clears it. req_ready is low while a response is pending.
- R8: Reset clears the holding register to 0, drives latch and pulse low, clears any pending response and restarts the scan timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pad_data_n | input | 1 | Serial data from the pad, active low |
| pad_latch | output | 1 | Latch strobe to the pad |
| pad_pulse | output | 1 | Shift clock pulse to the pad |
| req_valid | input | 1 | Host asks for the button snapshot |
| req_ready | output | 1 | Block can take a request |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Host takes the response beat |
| rsp_buttons | output | 8 | Button byte, 1 = pressed, A at bit 7, Right at bit 0 |

## Verification
The hardest case to reach is a request that lands in the middle of a scan, after the buttons changed but before the eighth sample. Only there does a partial write become visible. The stimulus changes the pad model's buttons during the idle gap before a scan, then polls at a fixed offset inside the latch-and-shift window, and polls again just after the final sample. A behavioural pad that shifts on each pulse edge and a cycle-level timing model check every latch and pulse cycle across several button patterns.

// File: rtl/padrd_pkg.sv
package padrd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LATCH, ST_LOW, ST_HIGH} pad_st_e;

  function automatic int us_to_cyc(input longint hz, input longint us);
    return int'((hz * us) / 64'd1000000);
  endfunction
endpackage

// File: rtl/padrd_tick.sv
module padrd_tick #(
  parameter int PERIOD = 4166666
) (
  input  logic clk,
  input  logic rst,
  output logic frame_go
);
  localparam int W = $clog2(PERIOD);
  logic [W-1:0] tcnt;

  assign frame_go = (tcnt == W'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst)           tcnt <= '0;
    else if (frame_go) tcnt <= '0;
    else               tcnt <= tcnt + 1'b1;
  end
endmodule

// File: rtl/padrd_sync.sv
module padrd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d_in};
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/padrd_shift.sv
module padrd_shift
  import padrd_pkg::*;
#(
  parameter int LATCH_CYC = 3000,
  parameter int HALF_CYC  = 1500,
  parameter int NBITS     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_go,
  input  logic             bit_n,
  output logic             latch,
  output logic             pulse,
  output logic             busy,
  output logic [NBITS-1:0] btn_hold
);
  localparam int MAXC = (LATCH_CYC > HALF_CYC) ? LATCH_CYC : HALF_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int BW   = $clog2(NBITS);

  pad_st_e          st;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bidx;
  logic [NBITS-1:0] sh;
  logic             wr_en;
  logic [NBITS-1:0] next_sh;

  assign busy    = (st != ST_IDLE);
  assign next_sh = {sh[NBITS-2:0], ~bit_n};
  assign wr_en   = (st == ST_LOW) && (cnt == CW'(HALF_CYC - 1)) && (bidx == BW'(NBITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      bidx     <= '0;
      sh       <= '0;
      latch    <= 1'b0;
      pulse    <= 1'b0;
      btn_hold <= '0;
    end else begin
      case (st)
        ST_IDLE: if (frame_go) begin
          st    <= ST_LATCH;
          cnt   <= '0;
          bidx  <= '0;
          latch <= 1'b1;
        end
        ST_LATCH: begin
          if (cnt == CW'(LATCH_CYC - 1)) begin
            st    <= ST_LOW;
            cnt   <= '0;
            latch <= 1'b0;
          end else cnt <= cnt + 1'b1;
        end
        ST_LOW: begin
          if (cnt == CW'(HALF_CYC - 1)) begin
            sh  <= next_sh;
            cnt <= '0;
            if (wr_en) begin
              btn_hold <= next_sh;
              st       <= ST_IDLE;
            end else begin
              st    <= ST_HIGH;
              pulse <= 1'b1;
              bidx  <= bidx + 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (cnt == CW'(HALF_CYC - 1)) begin
            st    <= ST_LOW;
            cnt   <= '0;
            pulse <= 1'b0;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(latch && pulse)); // R3
  AST_WRITE_ENDS_SCAN: assert property (@(posedge clk) disable iff (rst) wr_en |=> !busy && !pulse); // R5
  AST_LATCH_FROM_IDLE: assert property (@(posedge clk) disable iff (rst) $rose(latch) |-> $past(st) == ST_IDLE); // R1
endmodule

// File: rtl/padrd_poll.sv
module padrd_poll #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBITS-1:0] hold_in,
  input  logic             req_valid,
  output logic             req_ready,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [NBITS-1:0] rsp_data
);
  assign req_ready = !rsp_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rsp_valid) begin
      if (rsp_ready) rsp_valid <= 1'b0;
    end else if (req_valid) begin
      rsp_valid <= 1'b1;
      rsp_data  <= hold_in;
    end
  end

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (rst) rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R7
  AST_RSP_SNAPSHOT: assert property (@(posedge clk) disable iff (rst) $rose(rsp_valid) |-> rsp_data == $past(hold_in)); // R7
endmodule

// File: rtl/pad_reader.sv
module pad_reader
  import padrd_pkg::*;
#(
  parameter int CLK_HZ   = 250000000,
  parameter int POLL_HZ  = 60,
  parameter int LATCH_US = 12,
  parameter int HALF_US  = 6,
  parameter int NBITS    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pad_data_n,
  output logic             pad_latch,
  output logic             pad_pulse,
  input  logic             req_valid,
  output logic             req_ready,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [NBITS-1:0] rsp_buttons
);
  localparam int PERIOD    = CLK_HZ / POLL_HZ;
  localparam int LATCH_CYC = us_to_cyc(longint'(CLK_HZ), longint'(LATCH_US));
  localparam int HALF_CYC  = us_to_cyc(longint'(CLK_HZ), longint'(HALF_US));

  logic             frame_go;
  logic             bit_n;
  logic             busy;
  logic [NBITS-1:0] hold;

  padrd_tick #(.PERIOD(PERIOD)) i_tick (
    .clk(clk), .rst(rst), .frame_go(frame_go)
  );

  padrd_sync #(.STAGES(2)) i_sync (
    .clk(clk), .rst(rst), .d_in(pad_data_n), .d_out(bit_n)
  );

  padrd_shift #(.LATCH_CYC(LATCH_CYC), .HALF_CYC(HALF_CYC), .NBITS(NBITS)) i_shift (
    .clk(clk), .rst(rst), .frame_go(frame_go), .bit_n(bit_n),
    .latch(pad_latch), .pulse(pad_pulse), .busy(busy), .btn_hold(hold)
  );

  padrd_poll #(.NBITS(NBITS)) i_poll (
    .clk(clk), .rst(rst), .hold_in(hold),
    .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_buttons)
  );

  AST_SCAN_FITS_PERIOD: assert property (@(posedge clk) disable iff (rst) frame_go |-> !busy); // R1
endmodule

// File: tb/test_pad_reader.sv
`timescale 1ns/1ps
module test_pad_reader;
  localparam int P = 16666;
  localparam int L = 12;
  localparam int H = 6;
  localparam int LAST = L + 15 * H;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pad_data_n;
  logic pad_latch, pad_pulse;
  logic req_valid = 1'b0;
  logic req_ready, rsp_valid;
  logic rsp_ready = 1'b0;
  logic [7:0] rsp_buttons;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] btn = 8'h00;
  logic [7:0] psh = 8'h00;

  always #2 clk = ~clk;

  pad_reader #(.CLK_HZ(1000000)) i_pad_reader (
    .clk(clk), .rst(rst), .pad_data_n(pad_data_n),
    .pad_latch(pad_latch), .pad_pulse(pad_pulse),
    .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_buttons(rsp_buttons)
  );

  // behavioural pad: loads on latch, shifts on each pulse rise, drives active low
  always @(posedge pad_latch) psh = btn;
  always @(posedge pad_pulse) psh = {psh[6:0], 1'b0};
  assign pad_data_n = ~psh[7];

  // reference model
  int k = 0;
  bit m_latch, m_pulse, m_rv;
  logic [7:0] m_hold, m_rd;

  always @(posedge clk) begin
    if (rst) begin
      k = 0; m_latch = 0; m_pulse = 0; m_rv = 0; m_hold = 0; m_rd = 0;
    end else begin
      k = k + 1;
      if (m_rv) begin
        if (rsp_ready) m_rv = 0;
      end else if (req_valid) begin
        m_rv = 1; m_rd = m_hold;
      end
      m_latch = 0; m_pulse = 0;
      if (k >= P) begin
        int r;
        r = k % P;
        if (r < L) m_latch = 1;
        else if (r >= L + H && r < LAST) m_pulse = (((r - L - H) % (2 * H)) < H);
        if (r == LAST) m_hold = btn;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at k=%0d", req, act, exp, k);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && k > 0 && !done) begin
      check(pad_latch == m_latch, "R1 R2 latch", pad_latch, m_latch);
      check(pad_pulse == m_pulse, "R3 pulse", pad_pulse, m_pulse);
      check(rsp_valid == m_rv, "R7 rsp_valid", rsp_valid, m_rv);
      check(req_ready == !m_rv, "R7 req_ready", req_ready, !m_rv);
      if (m_rv) check(rsp_buttons == m_rd, "R7 rsp_buttons", rsp_buttons, m_rd);
    end
  end

  task automatic wait_k(input int target);
    while (k < target) @(negedge clk);
  endtask

  task automatic poll(input logic [7:0] exp, input string req);
    @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1, req, rsp_valid, 1);
    check(rsp_buttons == exp, req, rsp_buttons, exp);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R8: reset state
    check(pad_latch == 1'b0, "R8 latch low", pad_latch, 0);
    check(pad_pulse == 1'b0, "R8 pulse low", pad_pulse, 0);
    check(rsp_valid == 1'b0, "R8 no response", rsp_valid, 0);
    rst = 1'b0;
    poll(8'h00, "R8 hold cleared");

    // R4 R6: mixed pattern, scan 1
    btn = 8'hA5;
    wait_k(P + LAST + 4);
    poll(8'hA5, "R4 R6 pattern A5");

    // R7: back-pressure holds the response, blocks new requests
    @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    repeat (5) begin
      @(negedge clk);
      check(rsp_valid && rsp_buttons == 8'hA5, "R7 held under back-pressure", rsp_buttons, 8'hA5);
      check(req_ready == 1'b0, "R7 req_ready low while pending", req_ready, 0);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(rsp_valid == 1'b0, "R7 cleared by rsp_ready", rsp_valid, 0);

    // R5: poll mid-scan returns previous byte
    btn = 8'h3C;
    wait_k(2 * P + L + 7 * H);
    poll(8'hA5, "R5 mid-scan keeps old byte");
    wait_k(2 * P + LAST - 3);
    poll(8'hA5, "R5 just before last sample");
    wait_k(2 * P + LAST + 2);
    poll(8'h3C, "R5 new byte after last sample");

    // R4: single buttons, first bit to bit 7, last to bit 0
    btn = 8'h80;
    wait_k(3 * P + LAST + 2);
    poll(8'h80, "R4 A only at bit 7");
    btn = 8'h01;
    wait_k(4 * P + LAST + 2);
    poll(8'h01, "R4 Right only at bit 0");

    // R6: all and none
    btn = 8'hFF;
    wait_k(5 * P + LAST + 2);
    poll(8'hFF, "R6 all pressed");
    btn = 8'h00;
    wait_k(6 * P + LAST + 2);
    poll(8'h00, "R6 none pressed");

    // R1: latch rises right at the period boundary
    wait_k(7 * P - 1);
    check(pad_latch == 1'b0, "R1 latch low before boundary", pad_latch, 0);
    @(negedge clk);
    check(pad_latch == 1'b1, "R1 latch high at boundary", pad_latch, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", k, 7 * P);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule